// File: doc/BRIEF.md
# Serial-Clock Hold Detector for Sync and Power-Down

This block watches a serial clock line that normally rests low. It counts conversion frames while the line is held high. A frame is marked by a one-cycle frame-boundary strobe. A short hold puts the modulator and the decimation filter into reset, so that several converters can be aligned. A longer hold also asserts power-down.

On entry to reset, the block takes control of the data-ready pin. It drives the pin low for a fixed number of system clocks and then holds it high. The pin stays high until the serial clock falls. A falling serial clock releases both reset and power-down. The filter then restarts from a clean state, so the first ready pulse after release carries settled data.

The serial clock input must already be synchronized to the system clock. The analog power gating and the data shifter are outside this block. They act on the `modReset` and `pwrDown` outputs. The pin multiplexer uses `rdyForce` and `rdyLevel`.

Top module: `sclk_hold_detect`

## Requirements
- R1: After reset: `modReset`=0, `pwrDown`=0, `rdyForce`=0 and `rdyLevel`=1.
- R2: A frame strobe counts only while `sclkSync` is 1. A hold that ends (sclkSync=0) before `SYNC_FRAMES` strobes leaves all outputs idle.
- R3: On the clock edge that samples the `SYNC_FRAMES`-th counted strobe, `modReset` and `rdyForce` both become 1.
- R4: From that same edge, `rdyLevel` is 0 for exactly `PULSE_CYCLES` cycles. It is then 1 for as long as `rdyForce` stays 1.
- R5: On the edge that samples the `PD_FRAMES`-th counted strobe, `pwrDown` becomes 1 and `modReset` stays 1.
- R6: A hold of at least `SYNC_FRAMES` but fewer than `PD_FRAMES` strobes, ended by a low level, never raises `pwrDown`.
- R7: On the first edge that samples `sclkSync`=0 while `modReset` is 1, the block releases. `modReset`, `pwrDown` and `rdyForce` all go to 0, and `rdyLevel` goes to 1.
- R8: The frame count saturates at `PD_FRAMES`. Any number of extra strobes in power-down keeps `pwrDown` at 1. After release, counting restarts from zero.
- R9: A frame strobe sampled in the same cycle as `sclkSync`=0 is not counted. That cycle clears the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclkSync | input | 1 | Serial clock, already synchronized to clk |
| frameTick | input | 1 | One-cycle strobe at each conversion-frame boundary |
| modReset | output | 1 | Holds the modulator and filter in reset |
| pwrDown | output | 1 | Power-down request |
| rdyForce | output | 1 | Ready-pin override enable |
| rdyLevel | output | 1 | Level driven on the ready pin while the override is on |

## Verification
The bench builds the block with `SYNC_FRAMES`=3, `PD_FRAMES`=7 and `PULSE_CYCLES`=2. These small values let one run reach every threshold: the sync edge, the power-down edge and ten strobes past saturation. A pulse of two cycles makes any off-by-one in the low-pulse length show on the pin. The three values are all different, so a threshold compared against the wrong parameter shows up as entry on the wrong strobe.

// File: rtl/sclk_hold_pkg.sv
package sclk_hold_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_SYNC  = 2'd1,
    MODE_SLEEP = 2'd2
  } holdMode_t;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic pulseLoad;
  } holdStrb_t;

endpackage

// File: rtl/hold_count_path.sv
module hold_count_path
  import sclk_hold_pkg::*;
#(
  parameter int SYNC_FRAMES  = 4,
  parameter int PD_FRAMES    = 20,
  parameter int PULSE_CYCLES = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  holdStrb_t strb,
  output logic      atSyncEdge,
  output logic      atPdEdge,
  output logic      saturated,
  output logic      pulseActive
);

  localparam int CNT_W = $clog2(PD_FRAMES + 1);
  localparam int PLS_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(SYNC_FRAMES - 1);
  localparam logic [CNT_W-1:0] PD_LAST   = CNT_W'(PD_FRAMES - 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(PD_FRAMES);
  localparam logic [PLS_W-1:0] PLS_INIT  = PLS_W'(PULSE_CYCLES);

  logic [CNT_W-1:0] holdCnt;
  logic [PLS_W-1:0] pulseCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              holdCnt <= '0;
    else if (strb.cntClear)  holdCnt <= '0;
    else if (strb.cntInc)    holdCnt <= holdCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pulseCnt <= '0;
    else if (strb.cntClear)    pulseCnt <= '0;
    else if (strb.pulseLoad)   pulseCnt <= PLS_INIT;
    else if (pulseCnt != '0)   pulseCnt <= pulseCnt - 1'b1;
  end

  assign atSyncEdge  = (holdCnt == SYNC_LAST);
  assign atPdEdge    = (holdCnt == PD_LAST);
  assign saturated   = (holdCnt == CNT_MAX);
  assign pulseActive = (pulseCnt != '0);

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    holdCnt <= CNT_MAX);

  // R9
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.cntClear |=> (holdCnt == '0));

  // R4
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.pulseLoad |=> (pulseCnt == PLS_INIT));

endmodule

// File: rtl/hold_mode_ctl.sv
module hold_mode_ctl
  import sclk_hold_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclkSync,
  input  logic      frameTick,
  input  logic      atSyncEdge,
  input  logic      atPdEdge,
  input  logic      saturated,
  input  logic      pulseActive,
  output holdStrb_t strb,
  output logic      modReset,
  output logic      pwrDown,
  output logic      rdyForce,
  output logic      rdyLevel
);

  holdMode_t mode, modeNext;
  logic      countEvt;

  assign countEvt = sclkSync && frameTick;

  always_comb begin
    strb.cntClear  = !sclkSync;
    strb.cntInc    = countEvt && !saturated;
    strb.pulseLoad = (mode == MODE_RUN) && countEvt && atSyncEdge;
  end

  always_comb begin
    modeNext = mode;
    if (!sclkSync) begin
      modeNext = MODE_RUN;
    end else begin
      unique case (mode)
        MODE_RUN:   if (countEvt && atSyncEdge) modeNext = MODE_SYNC;
        MODE_SYNC:  if (countEvt && atPdEdge)   modeNext = MODE_SLEEP;
        MODE_SLEEP: modeNext = MODE_SLEEP;
        default:    modeNext = MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= MODE_RUN;
    else        mode <= modeNext;
  end

  assign modReset = (mode != MODE_RUN);
  assign pwrDown  = (mode == MODE_SLEEP);
  assign rdyForce = (mode != MODE_RUN);
  assign rdyLevel = !pulseActive;

  // R5
  sleep_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwrDown |-> modReset);

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclkSync |=> (!modReset && !pwrDown && !rdyForce && rdyLevel));

  // R5
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwrDown) |-> $past(countEvt));

  // R3
  sync_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modReset) |-> ($past(countEvt) && !rdyLevel));

  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdyForce |-> rdyLevel);

endmodule

// File: rtl/sclk_hold_detect.sv
module sclk_hold_detect
  import sclk_hold_pkg::*;
#(
  parameter int SYNC_FRAMES  = 4,
  parameter int PD_FRAMES    = 20,
  parameter int PULSE_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclkSync,
  input  logic frameTick,
  output logic modReset,
  output logic pwrDown,
  output logic rdyForce,
  output logic rdyLevel
);

  holdStrb_t strb;
  logic atSyncEdge, atPdEdge, saturated, pulseActive;

  hold_mode_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclkSync   (sclkSync),
    .frameTick  (frameTick),
    .atSyncEdge (atSyncEdge),
    .atPdEdge   (atPdEdge),
    .saturated  (saturated),
    .pulseActive(pulseActive),
    .strb       (strb),
    .modReset   (modReset),
    .pwrDown    (pwrDown),
    .rdyForce   (rdyForce),
    .rdyLevel   (rdyLevel)
  );

  hold_count_path #(
    .SYNC_FRAMES (SYNC_FRAMES),
    .PD_FRAMES   (PD_FRAMES),
    .PULSE_CYCLES(PULSE_CYCLES)
  ) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .atSyncEdge (atSyncEdge),
    .atPdEdge   (atPdEdge),
    .saturated  (saturated),
    .pulseActive(pulseActive)
  );

endmodule

// File: tb/sclk_hold_detect_tb.sv
module sclk_hold_detect_tb;

  localparam int SYNC_N  = 3;
  localparam int PD_N    = 7;
  localparam int PULSE_N = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclkSync = 1'b0;
  logic frameTick = 1'b0;
  logic modReset, pwrDown, rdyForce, rdyLevel;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sclk_hold_detect #(
    .SYNC_FRAMES (SYNC_N),
    .PD_FRAMES   (PD_N),
    .PULSE_CYCLES(PULSE_N)
  ) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclkSync (sclkSync),
    .frameTick(frameTick),
    .modReset (modReset),
    .pwrDown  (pwrDown),
    .rdyForce (rdyForce),
    .rdyLevel (rdyLevel)
  );

  task automatic check(string req, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic checkIdle(string req);
    check(req, "modReset", modReset, 1'b0);
    check(req, "pwrDown",  pwrDown,  1'b0);
    check(req, "rdyForce", rdyForce, 1'b0);
    check(req, "rdyLevel", rdyLevel, 1'b1);
  endtask

  // One frame strobe; returns at the negedge after the sampling edge.
  task automatic tick();
    @(negedge clk) frameTick = 1'b1;
    @(negedge clk) frameTick = 1'b0;
  endtask

  task automatic releaseHold();
    @(negedge clk) sclkSync = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    checkIdle("R1");
  endtask

  task automatic testShortHold();
    @(negedge clk) sclkSync = 1'b1;
    for (int i = 0; i < SYNC_N - 1; i++) tick();
    checkIdle("R2");
    releaseHold();
    checkIdle("R2");
    tick();
    checkIdle("R2");
  endtask

  task automatic testSyncOnly();
    bit sawSleep = 1'b0;
    @(negedge clk) sclkSync = 1'b1;
    for (int i = 0; i < SYNC_N - 1; i++) tick();
    check("R3", "modReset before threshold", modReset, 1'b0);
    tick();
    check("R3", "modReset", modReset, 1'b1);
    check("R3", "rdyForce", rdyForce, 1'b1);
    check("R4", "rdyLevel pulse start", rdyLevel, 1'b0);
    for (int c = 1; c < PULSE_N; c++) begin
      @(negedge clk);
      check("R4", "rdyLevel pulse body", rdyLevel, 1'b0);
    end
    @(negedge clk);
    check("R4", "rdyLevel after pulse", rdyLevel, 1'b1);
    for (int i = SYNC_N; i < PD_N - 1; i++) begin
      tick();
      if (pwrDown) sawSleep = 1'b1;
    end
    check("R4", "rdyLevel held high", rdyLevel, 1'b1);
    check("R6", "pwrDown stays low", sawSleep, 1'b0);
    releaseHold();
    checkIdle("R7");
  endtask

  task automatic testPowerDown();
    @(negedge clk) sclkSync = 1'b1;
    for (int i = 0; i < PD_N - 1; i++) tick();
    check("R5", "pwrDown before threshold", pwrDown, 1'b0);
    tick();
    check("R5", "pwrDown", pwrDown, 1'b1);
    check("R5", "modReset", modReset, 1'b1);
    for (int i = 0; i < 10; i++) tick();
    check("R8", "pwrDown after saturation", pwrDown, 1'b1);
    check("R8", "rdyLevel in sleep", rdyLevel, 1'b1);
    releaseHold();
    checkIdle("R7");
    @(negedge clk) sclkSync = 1'b1;
    for (int i = 0; i < SYNC_N - 1; i++) tick();
    check("R8", "count restarted", modReset, 1'b0);
    releaseHold();
  endtask

  task automatic testLowWins();
    @(negedge clk) sclkSync = 1'b1;
    for (int i = 0; i < SYNC_N - 1; i++) tick();
    @(negedge clk) begin sclkSync = 1'b0; frameTick = 1'b1; end
    @(negedge clk) begin sclkSync = 1'b1; frameTick = 1'b0; end
    checkIdle("R9");
    for (int i = 0; i < SYNC_N - 1; i++) tick();
    check("R9", "no entry after cleared count", modReset, 1'b0);
    tick();
    check("R9", "entry after full count", modReset, 1'b1);
    releaseHold();
    checkIdle("R7");
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testShortHold();
    testSyncOnly();
    testPowerDown();
    testLowWins();
    repeat (2) @(negedge clk);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule